// File: doc/BRIEF.md
# Memory Bus Wiring Test Engine

This block is a hardware sequencer that checks how an external memory's data and address lines are wired. It drives the memory through a simple master port: a request/acknowledge handshake with one word access in flight at a time. A one-cycle `start_i` pulse launches a run. The `addr_mask_i` input gives the memory size minus one and is sampled when the start is accepted. The engine then tests the data lines and the address lines in turn.

The data test walks a single set bit across the word at the base address, with one write and one read per bit. The address test uses power-of-two byte offsets. It first fills every offset with an alternating-bit pattern. A stuck-high pass then writes the complementary pattern at offset 0. A stuck-low and short pass writes the complementary pattern at each test offset in turn and checks the other locations. The first mismatch ends the run. At the end a one-cycle `done_o` reports `pass_o` and the failing byte address.

Top module: `mbt_engine`

## Requirements
- R1: The data test writes the value with only bit k set to the base address BASE, for k = 0 up to DW-1 in ascending order, and reads each value back right after writing it. The first readback that differs ends the run with pass_o=0 and fail_addr_o=BASE.
- R2: Address offsets are byte offsets. They start at DW/8, double at each step, and are used only while (offset & mask) is nonzero. A mask with no bit set at or above bit log2(DW/8) gives no offsets, so the only address accesses left are the two writes to offset 0.
- R3: After the data test, 0xAAAAAAAA (alternating bits, bit 0 clear) is written at every offset in ascending order.
- R4: The stuck-high pass writes 0x55555555 at offset 0 and then reads every offset in ascending order, each of which must read 0xAAAAAAAA. The first mismatch ends the run with fail_addr_o=BASE+offset. Otherwise 0xAAAAAAAA is written back to offset 0.
- R5: The stuck-low and short pass takes each offset t in ascending order and does the following. It writes 0x55555555 at t and reads offset 0; a value other than 0xAAAAAAAA ends the run with fail_addr_o=BASE. It then reads every offset except t in ascending order; t itself is not read, and the first value other than 0xAAAAAAAA ends the run with fail_addr_o=BASE+offset. Finally it writes 0xAAAAAAAA back at t. For N offsets, a run that passes makes 2*DW+2+2N+N*(N+2) accesses.
- R6: When a run completes with no mismatch, the engine reports pass_o=1 and fail_addr_o=0. After a mismatch it reports pass_o=0.
- R7: mem_req_o stays high, with mem_addr_o, mem_we_o and mem_wdata_o stable, until mem_ack_i arrives. It drops in the cycle after the acknowledge. Read data is taken in the acknowledge cycle, and correct operation does not depend on how long the acknowledge takes.
- R8: A start is accepted only when busy_o is low. An accepted start clears pass_o and fail_addr_o and raises busy_o in the next cycle. A start while busy has no effect. done_o is high for one cycle, in the same cycle that busy_o falls. The results then hold until the next accepted start.
- R9: While reset is asserted, busy_o, done_o, pass_o, fail_addr_o and mem_req_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| addr_mask_i | input | AW | Memory size minus one |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | The last run found no fault |
| fail_addr_o | output | AW | Failing byte address, zero on pass |
| mem_req_o | output | 1 | Access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access complete |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |

## Verification
The engine runs against a memory model with injected faults. A fault-free memory is tried with the full mask, a narrow mask and a mask that leaves no offsets; the access counts show the offset range and the skipped self-read. Data bits stuck low and stuck high must be reported at the base address. Address bits stuck high at the lowest, middle and top offset bits are reported at their own offset in the stuck-high pass. An address bit stuck low, a wired-OR short between two address bits and a fault present only on the write path each surface in a different pass. Together these show which pass caught each fault and which address it reported. Ack latency is varied to exercise the handshake.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_D_WR, ST_D_RD, ST_FILL, ST_H_WR, ST_H_RD,
    ST_H_RST, ST_L_WR, ST_L_RD0, ST_L_RD, ST_L_RST
  } mbt_state_e;
endpackage

// File: rtl/mbt_port.sv
module mbt_port #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_off_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic fire;
  assign fire = mem_req_o & mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        mem_req_o <= 1'b0;
        if (!mem_we_o) rsp_rdata_o <= mem_rdata_i;
      end else if (cmd_valid_i) begin
        mem_req_o   <= 1'b1;
        mem_we_o    <= cmd_we_i;
        mem_addr_o  <= BASE + cmd_off_i;
        mem_wdata_o <= cmd_wdata_i;
      end
    end
  end

  assert_hold_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  assert_drop_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o && rsp_valid_o);
  assert_one_outstanding_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !mem_req_o && !rsp_valid_o);
  assert_rdata_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_we_o |=> rsp_rdata_o == $past(mem_rdata_i));
endmodule

// File: rtl/mbt_seq.sv
module mbt_seq
  import mbt_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_mask_i,
  output logic          cmd_valid_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_off_o,
  output logic [DW-1:0] cmd_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam logic [AW-1:0] STEP  = AW'(DW / 8);
  localparam logic [DW-1:0] PAT_A = {(DW / 2){2'b10}};
  localparam logic [DW-1:0] PAT_5 = {(DW / 2){2'b01}};

  mbt_state_e    state_q, state_d;
  logic          pend_q;
  logic [DW-1:0] pat_q, pat_d;
  logic [AW-1:0] off_q, off_d, tst_q, tst_d, mask_q;
  logic [AW-1:0] first_chk, skip_chk, fin_addr;
  logic          fin, fin_ok, miss_a;

  function automatic logic live(input logic [AW-1:0] o);
    return |(o & mask_q);
  endfunction

  assign first_chk = (STEP == tst_q) ? (STEP << 1) : STEP;
  assign skip_chk  = ((off_q << 1) == tst_q) ? (off_q << 2) : (off_q << 1);
  assign miss_a    = rsp_rdata_i != PAT_A;

  assign busy_o      = state_q != ST_IDLE;
  assign cmd_valid_o = busy_o && !pend_q;

  always_comb begin
    cmd_we_o    = 1'b1;
    cmd_off_o   = '0;
    cmd_wdata_o = PAT_A;
    case (state_q)
      ST_D_WR:  cmd_wdata_o = pat_q;
      ST_D_RD:  cmd_we_o = 1'b0;
      ST_FILL:  cmd_off_o = off_q;
      ST_H_WR:  cmd_wdata_o = PAT_5;
      ST_H_RD:  begin cmd_we_o = 1'b0; cmd_off_o = off_q; end
      ST_L_WR:  begin cmd_off_o = tst_q; cmd_wdata_o = PAT_5; end
      ST_L_RD0: cmd_we_o = 1'b0;
      ST_L_RD:  begin cmd_we_o = 1'b0; cmd_off_o = off_q; end
      ST_L_RST: cmd_off_o = tst_q;
      default: ;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    off_d    = off_q;
    tst_d    = tst_q;
    pat_d    = pat_q;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    fin_addr = '0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d = ST_D_WR;
        pat_d   = {{(DW - 1){1'b0}}, 1'b1};
      end
    end else if (rsp_valid_i) begin
      case (state_q)
        ST_D_WR: state_d = ST_D_RD;
        ST_D_RD: begin
          if (rsp_rdata_i != pat_q) begin
            fin = 1'b1; fin_addr = BASE;
          end else if (pat_q[DW-1]) begin
            off_d   = STEP;
            state_d = live(STEP) ? ST_FILL : ST_H_WR;
          end else begin
            pat_d   = pat_q << 1;
            state_d = ST_D_WR;
          end
        end
        ST_FILL: begin
          if (live(off_q << 1)) off_d = off_q << 1;
          else begin off_d = STEP; state_d = ST_H_WR; end
        end
        ST_H_WR: state_d = live(STEP) ? ST_H_RD : ST_H_RST;
        ST_H_RD: begin
          if (miss_a) begin
            fin = 1'b1; fin_addr = BASE + off_q;
          end else if (live(off_q << 1)) off_d = off_q << 1;
          else state_d = ST_H_RST;
        end
        ST_H_RST: begin
          tst_d = STEP;
          if (live(STEP)) state_d = ST_L_WR;
          else begin fin = 1'b1; fin_ok = 1'b1; end
        end
        ST_L_WR: state_d = ST_L_RD0;
        ST_L_RD0: begin
          if (miss_a) begin
            fin = 1'b1; fin_addr = BASE;
          end else begin
            off_d   = first_chk;
            state_d = live(first_chk) ? ST_L_RD : ST_L_RST;
          end
        end
        ST_L_RD: begin
          if (miss_a) begin
            fin = 1'b1; fin_addr = BASE + off_q;
          end else if (live(skip_chk)) off_d = skip_chk;
          else state_d = ST_L_RST;
        end
        ST_L_RST: begin
          if (live(tst_q << 1)) begin
            tst_d = tst_q << 1; state_d = ST_L_WR;
          end else begin
            fin = 1'b1; fin_ok = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= 1'b0;
      pat_q       <= '0;
      off_q       <= '0;
      tst_q       <= '0;
      mask_q      <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_addr_o <= '0;
    end else begin
      state_q <= state_d;
      pat_q   <= pat_d;
      off_q   <= off_d;
      tst_q   <= tst_d;
      done_o  <= fin;
      if (cmd_valid_o) pend_q <= 1'b1;
      else if (rsp_valid_i) pend_q <= 1'b0;
      if (fin) begin
        pass_o      <= fin_ok;
        fail_addr_o <= fin_ok ? '0 : fin_addr;
      end else if (state_q == ST_IDLE && start_i) begin
        mask_q      <= addr_mask_i;
        pass_o      <= 1'b0;
        fail_addr_o <= '0;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_hold_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(pass_o) && $stable(fail_addr_o));
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  assert_pass_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> fail_addr_o == '0);
endmodule

// File: rtl/mbt_engine.sv
module mbt_engine #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] BASE = 'h4000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fail_addr_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          cmd_valid, cmd_we, rsp_valid;
  logic [AW-1:0] cmd_off;
  logic [DW-1:0] cmd_wdata, rsp_rdata;

  mbt_seq #(.AW(AW), .DW(DW), .BASE(BASE)) u_seq (
    .clk_i, .rst_ni, .start_i, .addr_mask_i,
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we), .cmd_off_o(cmd_off),
    .cmd_wdata_o(cmd_wdata), .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .busy_o, .done_o, .pass_o, .fail_addr_o
  );

  mbt_port #(.AW(AW), .DW(DW), .BASE(BASE)) u_port (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_off_i(cmd_off),
    .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );
endmodule

// File: tb/sim_mbt_engine.sv
`timescale 1ns/1ps
module sim_mbt_engine;
  localparam logic [31:0] BASE = 32'h4000_0000;

  typedef struct packed {
    logic [2:0]  kind;  // 0 none,1 rd data low,2 rd data high,3 addr high,4 addr low,5 OR short,6 write addr low
    logic [3:0]  p;
    logic [3:0]  q;
    logic [11:0] mask;
    logic [1:0]  lat;
    logic        pass;
    logic [11:0] off;
    logic [8:0]  acc;   // 0 = not checked
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd0,  4'd0, 12'hFFF, 2'd0, 1'b1, 12'h000, 9'd206}, // R2 R5 R6 fault-free
    '{3'd1, 4'd5,  4'd0, 12'hFFF, 2'd0, 1'b0, 12'h000, 9'd0},   // R1
    '{3'd2, 4'd0,  4'd0, 12'hFFF, 2'd2, 1'b0, 12'h000, 9'd0},   // R1
    '{3'd3, 4'd6,  4'd0, 12'hFFF, 2'd0, 1'b0, 12'h040, 9'd0},   // R4
    '{3'd4, 4'd7,  4'd0, 12'hFFF, 2'd0, 1'b0, 12'h080, 9'd0},   // R3 R4
    '{3'd5, 4'd3,  4'd9, 12'hFFF, 2'd1, 1'b0, 12'h200, 9'd0},   // R5 short
    '{3'd6, 4'd8,  4'd0, 12'hFFF, 2'd0, 1'b0, 12'h000, 9'd0},   // R5 base
    '{3'd3, 4'd11, 4'd0, 12'hFFF, 2'd0, 1'b0, 12'h800, 9'd0},   // R4 top
    '{3'd3, 4'd2,  4'd0, 12'hFFF, 2'd0, 1'b0, 12'h004, 9'd0},   // R4 lowest
    '{3'd3, 4'd8,  4'd0, 12'h03F, 2'd0, 1'b1, 12'h000, 9'd98},  // R2 narrow
    '{3'd4, 4'd2,  4'd0, 12'h003, 2'd0, 1'b1, 12'h000, 9'd66},  // R2 no offsets
    '{3'd0, 4'd0,  4'd0, 12'hFFF, 2'd3, 1'b1, 12'h000, 9'd206}  // R7 slow ack
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] mask = '0;
  logic busy, done, pass;
  logic [31:0] fail_addr, mem_addr, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ack;

  int kind = 0, fp = 0, fq = 0, lat = 0, lcnt = 0;
  logic preload = 1'b0, mon_clr = 1'b0;
  logic [31:0] mem [1024];
  int acc_cnt = 0, done_cnt = 0, viol = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  mbt_engine #(.AW(32), .DW(32), .BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_mask_i(mask),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_addr_o(fail_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [9:0] widx(input logic [31:0] a, input bit wr);
    logic [11:0] b;
    logic v;
    b = a[11:0];
    case (kind)
      3: b[fp] = 1'b1;
      4: b[fp] = 1'b0;
      5: begin v = b[fp] | b[fq]; b[fp] = v; b[fq] = v; end
      6: if (wr) b[fp] = 1'b0;
      default: ;
    endcase
    return b[11:2];
  endfunction

  function automatic logic [31:0] rdfault(input logic [31:0] d);
    logic [31:0] r;
    r = d;
    if (kind == 1) r[fp] = 1'b0;
    if (kind == 2) r[fp] = 1'b1;
    return r;
  endfunction

  // memory model and monitors
  always @(posedge clk) begin
    if (preload) for (int i = 0; i < 1024; i++) mem[i] <= 32'hAAAA_AAAA;
    if (!rst_n) begin
      mem_ack <= 1'b0; lcnt <= 0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      if (lcnt == lat) begin
        mem_ack <= 1'b1; lcnt <= 0;
        if (mem_we) mem[widx(mem_addr, 1'b1)] <= mem_wdata;
        else mem_rdata <= rdfault(mem[widx(mem_addr, 1'b0)]);
      end else lcnt <= lcnt + 1;
    end else mem_ack <= 1'b0;

    if (mon_clr) begin acc_cnt <= 0; done_cnt <= 0; end
    else begin
      if (mem_req && mem_ack) acc_cnt <= acc_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
    if (rst_n && prev_req && !prev_ack &&
        (!mem_req || mem_addr != prev_addr || mem_we != prev_we || mem_wdata != prev_wdata))
      viol <= viol + 1;
    if (rst_n && prev_req && prev_ack && mem_req) viol <= viol + 1;
    prev_req <= mem_req; prev_ack <= mem_ack; prev_we <= mem_we;
    prev_addr <= mem_addr; prev_wdata <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic setup(input vec_t v);
    @(negedge clk);
    kind = int'(v.kind); fp = int'(v.p); fq = int'(v.q); lat = int'(v.lat);
    mask = {20'd0, v.mask}; preload = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    preload = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (R8 run never completed) act=%0d exp=%0d", 0, 1);
    summary();
  end

  initial begin
    vec_t v;
    logic [31:0] exp_fa;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !pass && fail_addr == 0 && !mem_req, "R9 reset outputs",
          {busy, done, pass, mem_req}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      exp_fa = v.pass ? 32'd0 : BASE + {20'd0, v.off};
      setup(v);
      pulse_start();
      wait_done();
      check(pass == v.pass, $sformatf("R1 R4 R5 R6 vec%0d pass", i), {31'd0, pass}, {31'd0, v.pass});
      check(fail_addr == exp_fa, $sformatf("R1 R3 R4 R5 R6 vec%0d fail_addr", i), fail_addr, exp_fa);
      if (v.acc != 0)
        check(acc_cnt == int'(v.acc), $sformatf("R2 R5 vec%0d accesses", i), acc_cnt, {23'd0, v.acc});
      @(negedge clk);
      check(!done && done_cnt == 1, $sformatf("R8 vec%0d single done", i), done_cnt, 32'd1);
    end

    // R8 results hold after a failing run
    setup(VECS[3]);
    pulse_start();
    wait_done();
    repeat (20) @(negedge clk);
    check(!busy && !pass && fail_addr == BASE + 32'h40, "R8 result hold", fail_addr, BASE + 32'h40);

    // R8 accepted start clears results, start while busy ignored
    setup(VECS[0]);
    pulse_start();
    check(busy && !pass && fail_addr == 0, "R8 start clears results", fail_addr, 32'd0);
    repeat (30) @(negedge clk);
    check(busy, "R8 busy during run", {31'd0, busy}, 32'd1);
    pulse_start();
    wait_done();
    check(pass && acc_cnt == 206, "R8 start while busy ignored", acc_cnt, 32'd206);
    repeat (50) @(negedge clk);
    check(done_cnt == 1, "R8 one done per run", done_cnt, 32'd1);

    // R7 handshake monitor
    check(viol == 0, "R7 handshake violations", viol, 32'd0);
    summary();
  end
endmodule